// File: doc/BRIEF.md
# Prescaled Capture Timer

A 16-bit free-running timer with two input capture channels behind a byte-wide register bus. The count rate comes from a prescaler. It either divides the bus clock by a power of two from 1 to 64, or advances once per rising edge of an external timer clock pin.

Each channel synchronises its pin and detects edges on it. The edges that count are chosen per channel. On an active edge the channel copies the current count into its capture latch and raises its flag. When the channel's interrupt enable is set, the flag drives that channel's interrupt line.

Software reads a capture as a high byte and then a low byte. Reading the high byte freezes the latch until the low byte has been read, so the two bytes always belong to the same event. The mode, toggle and max-duty bits are kept as plain storage.

Top module: `cap_timer`

## Requirements
- R1: After reset, the control register and both channel status registers read 0x00, both capture registers read 0x0000, and `irq_o` is 0.
- R2: The control register sits at address 0 and holds the select in bits 2:0; bits 7:3 read as 0. A select k in the range 0 to 6 advances the counter once every 2^k bus cycles. The divider runs freely from reset, and a new select takes effect in the cycle after the write.
- R3: Select 7 advances the counter once for each rising edge of `ext_clk_i`. The pin passes through a two-flop synchroniser, and the edge is detected on the synchronised level.
- R4: Channel edge select is status bits 3:2, with bit 3 as the upper bit. The codes are 00 for no capture, 01 for rising, 10 for falling and 11 for both edges. The channel pin passes through two synchronising flops before edge detection.
- R5: An active edge copies the counter value into the channel's capture register. The count stored is the value held in the cycle the synchronised edge is seen. Channel c uses status at address 1+3c, capture high byte at 2+3c and capture low byte at 3+3c. Address 7 reads 0.
- R6: A capture sets status bit 7, the flag. `irq_o[c]` is high exactly while channel c's flag and its bit 6, the interrupt enable, are both set.
- R7: Writing the status register with bit 7 at 0 clears the flag. Writing bit 7 at 1 leaves the flag unchanged. A capture in the same cycle as a clearing write leaves the flag set.
- R8: Status bits 6:0 are stored as written and read back. The exception is channel 1, where bit 5 always reads 0.
- R9: A read strobe on a channel's high byte freezes that channel's capture register. A read strobe on its low byte releases it. Edges that arrive while the channel is frozen change neither the capture register nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External timer clock pin |
| cap_i | input | 2 | Capture pins, one per channel |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, drives the freeze logic |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 2 | Per-channel interrupt request |

## Verification
Some properties are checked on every cycle by assertions:
- the counter never moves by more than one step;
- a flag rises only after a detected edge on an unfrozen channel;
- a capture register changes only together with a set flag;
- a disabled or frozen channel keeps its latch.

Other behaviour can only be shown by the bench's scenarios, run against its cycle-accurate model:
- the actual rates of all eight selects;
- which edges each select code accepts;
- the value latched after the synchroniser delay;
- a clear racing a capture;
- the reserved channel-1 bit.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int STAT_FLAG = 7;
  localparam int STAT_IE   = 6;
  localparam int STAT_MSB  = 5;
  localparam int CH_STRIDE = 3;
  localparam int CH_FIRST  = 1;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PS_W-1:0] ps_i,
  input  logic            ext_clk_i,
  output logic            tick_o
);
  localparam int EXT_SEL = (1 << PS_W) - 1;
  localparam int DIV_W   = EXT_SEL - 1;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       ext_q;
  logic [DIV_W:0]   one_hot;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= div_q + DIV_W'(1);
      ext_q <= {ext_q[1:0], ext_clk_i};
    end
  end

  always_comb begin
    one_hot = (DIV_W+1)'(1) << ps_i;
    mask    = one_hot[DIV_W-1:0] - DIV_W'(1);
    if (ps_i == PS_W'(EXT_SEL)) tick_o = ext_q[1] & ~ext_q[2];
    else                        tick_o = (div_q & mask) == mask;
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_timer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter bit HAS_MSB = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_sc_i,
  input  logic              rd_hi_i,
  input  logic              rd_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] sc_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              irq_o
);
  localparam int CFG_W = DATA_W - 1;
  localparam logic [CFG_W-1:0] CFG_MASK =
    HAS_MSB ? {CFG_W{1'b1}} : ~(CFG_W'(1) << STAT_MSB);

  logic [2:0]       pin_q;
  logic [CFG_W-1:0] cfg_q;
  logic             flag_q, frz_q, rise, fall, hit;
  logic [CNT_W-1:0] cap_q;
  edge_sel_e        els;

  assign els  = edge_sel_e'(cfg_q[3:2]);
  assign rise = pin_q[1] & ~pin_q[2];
  assign fall = ~pin_q[1] & pin_q[2];

  always_comb begin
    unique case (els)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= '0;
      cfg_q  <= '0;
      flag_q <= 1'b0;
      frz_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      pin_q <= {pin_q[1:0], pin_i};
      if (wr_sc_i) begin
        cfg_q <= wdata_i[CFG_W-1:0] & CFG_MASK;
        if (!wdata_i[STAT_FLAG]) flag_q <= 1'b0;
      end
      if (hit && !frz_q) begin
        cap_q  <= cnt_i;
        flag_q <= 1'b1;
      end
      if (rd_hi_i)      frz_q <= 1'b1;
      else if (rd_lo_i) frz_q <= 1'b0;
    end
  end

  assign sc_o  = {flag_q, cfg_q};
  assign cap_o = cap_q;
  assign irq_o = flag_q & cfg_q[STAT_IE];

  // R6
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit && !frz_q));
  // R5
  cap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q != $past(cap_q)) |-> flag_q);
  // R4
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (els == EDGE_OFF) |=> $stable(cap_q));
  // R9
  frz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_q |=> $stable(cap_q));
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int PS_W   = 3,
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic [NUM_CH-1:0] cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [PS_W-1:0]   ps_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tick;
  logic [DATA_W-1:0] sc_w  [NUM_CH];
  logic [CNT_W-1:0]  cap_w [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i && addr_i == '0) ps_q <= wdata_i[PS_W-1:0];
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  cap_prescaler #(.PS_W(PS_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ps_i(ps_q),
    .ext_clk_i(ext_clk_i), .tick_o(tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_FIRST + CH_STRIDE * c);
    cap_channel #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .HAS_MSB(c == 0)
    ) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_i[c]), .cnt_i(cnt_q),
      .wr_sc_i(wr_i && addr_i == BASE),
      .rd_hi_i(rd_i && addr_i == BASE + ADDR_W'(1)),
      .rd_lo_i(rd_i && addr_i == BASE + ADDR_W'(2)),
      .wdata_i(wdata_i), .sc_o(sc_w[c]), .cap_o(cap_w[c]), .irq_o(irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = DATA_W'(ps_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(CH_FIRST + CH_STRIDE * c))     rdata_o = sc_w[c];
      if (addr_i == ADDR_W'(CH_FIRST + CH_STRIDE * c + 1)) rdata_o = cap_w[c][CNT_W-1:DATA_W];
      if (addr_i == ADDR_W'(CH_FIRST + CH_STRIDE * c + 2)) rdata_o = cap_w[c][DATA_W-1:0];
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: tb/cap_timer_tb.sv
module cap_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, ext = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] cap = 2'b00;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_div, m_cnt, m_ps;
  bit [2:0] m_ext;
  bit [2:0] m_pin [2];
  int m_cap [2];
  bit [6:0] m_cfg [2];
  bit m_flag [2], m_frz [2];

  cap_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .cap_i(cap),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_ps = 0; m_ext = 0;
      for (int c = 0; c < 2; c++) begin
        m_pin[c] = 0; m_cap[c] = 0; m_cfg[c] = 0; m_flag[c] = 0; m_frz[c] = 0;
      end
    end else begin
      automatic int mask = (1 << m_ps) - 1;
      automatic bit tk = (m_ps == 7) ? (m_ext[1] && !m_ext[2]) : ((m_div & mask) == mask);
      for (int c = 0; c < 2; c++) begin
        automatic int base = 1 + 3 * c;
        automatic bit r = m_pin[c][1] && !m_pin[c][2];
        automatic bit f = !m_pin[c][1] && m_pin[c][2];
        automatic int sel = m_cfg[c][3:2];
        automatic bit hit = (sel == 1 && r) || (sel == 2 && f) || (sel == 3 && (r || f));
        if (wr && addr == base) begin
          m_cfg[c] = wdata[6:0] & (c == 1 ? 7'h5f : 7'h7f);
          if (!wdata[7]) m_flag[c] = 0;
        end
        if (hit && !m_frz[c]) begin m_cap[c] = m_cnt; m_flag[c] = 1; end
        if (rd && addr == base + 1) m_frz[c] = 1;
        else if (rd && addr == base + 2) m_frz[c] = 0;
        m_pin[c] = {m_pin[c][1:0], cap[c]};
      end
      if (wr && addr == 0) m_ps = wdata & 7;
      m_cnt = (m_cnt + tk) & 16'hffff;
      m_div = (m_div + 1) & 63;
      m_ext = {m_ext[1:0], ext};
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_ps;
      1, 4: return {m_flag[(a-1)/3], m_cfg[(a-1)/3]};
      2, 5: return (m_cap[(a-2)/3] >> 8) & 255;
      3, 6: return m_cap[(a-3)/3] & 255;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, rdata, exp_rd(addr));
    for (int c = 0; c < 2; c++)
      check("R6 irq", irq[c], m_flag[c] && m_cfg[c][6]);
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr_reg(input int a, input int d);
    @(posedge clk); #1 wr = 1; addr = a[2:0]; wdata = d[7:0];
    @(posedge clk); #1 wr = 0;
  endtask
  task automatic rd_reg(input int a);
    @(posedge clk); #1 rd = 1; addr = a[2:0];
    @(posedge clk); #1 rd = 0;
  endtask
  task automatic pulse(input int c, input int hi, input int lo);
    @(posedge clk); #1 cap[c] = 1;
    idle(hi); cap[c] = 0;
    idle(lo);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset values at the ports
    check("R1 irq", irq, 0);
    check("R1 ctrl", rdata, 0);
    rst_n = 1;
    for (int a = 0; a < 8; a++) begin @(posedge clk); #1 addr = a[2:0]; end
    idle(1);

    cur_req = "R8";
    wr_reg(1, 8'h7f); idle(2);
    wr_reg(4, 8'hff); idle(2);
    addr = 1; idle(2);
    check("R8 ch1 bit5", (exp_rd(4) >> 5) & 1, 0);

    cur_req = "R2";
    wr_reg(0, 8'hfd); idle(2);
    for (int p = 0; p < 7; p++) begin
      wr_reg(0, p);
      wr_reg(1, 8'h44);
      addr = 3;
      for (int k = 0; k < 3; k++) begin
        pulse(0, 3, 5 + k * (1 << p));
        cur_req = "R5";
        addr = 2; idle(1);
        addr = 3; idle(1);
        cur_req = "R2";
      end
    end

    cur_req = "R3";
    wr_reg(0, 7); addr = 3;
    for (int k = 0; k < 12; k++) begin
      ext = 1; idle(3 + k % 3);
      ext = 0; idle(3);
      if (k % 4 == 3) pulse(0, 2, 2);
    end

    cur_req = "R4";
    wr_reg(0, 0);
    for (int e = 0; e < 4; e++) begin
      wr_reg(4, 8'h40 | (e << 2));
      addr = 6;
      pulse(1, 4, 6);
      wr_reg(4, 8'h40 | (e << 2));
      addr = 5; idle(2);
    end

    cur_req = "R7";
    wr_reg(1, 8'h44); addr = 1;
    for (int off = 0; off < 6; off++) begin
      @(posedge clk); #1 cap[0] = 1;
      idle(off);
      wr_reg(1, 8'h44);
      cap[0] = 0; idle(4);
      wr_reg(1, 8'hc4); idle(2);
      wr_reg(1, 8'h44); idle(2);
    end

    cur_req = "R9";
    idle(20);
    pulse(0, 3, 4);
    rd_reg(2);
    idle(10);
    pulse(0, 3, 6);
    addr = 1; idle(2);
    addr = 2; idle(2);
    rd_reg(3);
    idle(5);
    pulse(0, 3, 6);
    addr = 2; idle(2);
    addr = 7; idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule